// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the data-path core of a small 8-bit accumulator machine. In a single clock it takes the accumulator value, a second operand and an operation code. The second operand may come from a register, a memory byte or an immediate field. The block registers three outputs: a result byte, a write-back strobe for the accumulator, and a status byte that holds sign, zero, half carry, parity and carry.

Each operation class updates the flags under its own rule:

- Full arithmetic sets all five flags.
- Compare sets the flags without writing the accumulator.
- Logic operations clear carry.
- Single-operand step operations keep the carry flag.
- Rotates touch only carry.
- The carry-control and complement operations change only what they name.
- Decimal adjust corrects a binary sum to packed BCD.

The block does not fetch instructions, hold the register file or drive a bus. A surrounding sequencer asserts `exec_i` for one cycle per operation. It then takes `res_o` into the accumulator when `acc_we_o` is high. For step operations it writes `res_o` into the register it chose.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `res_o`=0x00, `acc_we_o`=0 and `flags_o`=0x02.
- R2: In `flags_o`, sign is bit 7, zero is bit 6, half carry is bit 4, parity is bit 2 and carry is bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R3: Codes 0 (add), 1 (add plus carry), 2 (subtract) and 3 (subtract with carry as borrow) write the result to the accumulator and set all five flags. For subtraction, carry is the borrow out of bit 7 and half carry is the borrow out of bit 3. For addition, both are the carry outs.
- R4: Code 7 (compare) sets flags exactly as code 2 would. `res_o` shows the difference and `acc_we_o` stays 0.
- R5: Code 4 (AND with a register) clears carry and sets half carry to the OR of both operands' bit 3. Code 18 (AND with an immediate), code 5 (XOR) and code 6 (OR) clear both carry and half carry. All four set sign, zero and parity from the result.
- R6: Code 8 (step up) and code 9 (step down) act on `opnd_i` alone. They update sign, zero, half carry and parity, keep carry, and leave `acc_we_o` at 0.
- R7: Codes 10 to 13 rotate the accumulator and change only the carry flag. Code 10 rotates left circularly and code 11 rotates right circularly. Code 12 rotates left through carry and code 13 rotates right through carry.
- R8: Code 14 writes the inverted accumulator and leaves every flag unchanged.
- R9: Code 15 sets carry and code 16 inverts carry. Both leave every other flag unchanged, put `acc_i` on `res_o` and hold `acc_we_o` at 0.
- R10: Code 17 (decimal adjust) first adds 0x06 if the low nibble exceeds 9 or half carry is set. It then adds 0x60 if the resulting high nibble exceeds 9, the first step overflowed, or carry is set; carry is 1 exactly when this second step is applied. Half carry is the carry out of bit 3 in the first step, and sign, zero and parity follow the result.
- R11: A clock edge with `exec_i` low holds `res_o` and `flags_o` and drives `acc_we_o` to 0.
- R12: Parity is 1 when the result holds an even number of 1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Perform the selected operation at this edge |
| op_i | input | 5 | Operation code (see requirements) |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand (register, memory or immediate) |
| res_o | output | 8 | Registered result |
| acc_we_o | output | 1 | Registered accumulator write-back strobe |
| flags_o | output | 8 | Registered status byte |

## Verification
The assertions check on every cycle that the flag byte's constant bits never change. They also check that compare and the step operations never raise write-back, that logic operations clear carry, and that rotates leave everything but carry alone. Further per-cycle checks cover the inverted accumulator produced by complement, the exact effect of set carry, and the hold behaviour when `exec_i` is low. Exact arithmetic values cannot be shown by those properties, so only the bench's scenarios demonstrate them. These are the half-carry and borrow conventions, the carry chain between consecutive add-with-carry and subtract-with-borrow operations, and each branch of decimal adjust. The bench runs operations back to back so that every one consumes the flags left by the one before.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int FLAG_W = 8;
  localparam int F_CY = 0;
  localparam int F_P  = 2;
  localparam int F_AC = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;
  localparam logic [FLAG_W-1:0] FLAG_ONES = 8'h02;
  localparam logic [FLAG_W-1:0] FLAG_LIVE = 8'hD5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND  = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC  = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL  = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC  = 5'd16, OP_DAA = 5'd17, OP_ANDI = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hout
);
  localparam int HW = DW / 2;

  logic [HW:0] lo;
  logic [DW:0] full;

  always_comb begin
    if (sub) begin
      lo   = {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]} - {{HW{1'b0}}, cin};
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
    end else begin
      lo   = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, cin};
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
    end
    sum  = full[DW-1:0];
    cout = full[DW];   // carry out, or borrow when subtracting
    hout = lo[HW];
  end
endmodule

// File: rtl/acc_alu_daa.sv
module acc_alu_daa #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          ac_in,
  input  logic          cy_in,
  output logic [DW-1:0] res,
  output logic          ac_out,
  output logic          cy_out
);
  localparam int HW = DW / 2;
  localparam logic [HW-1:0] DIG_MAX = HW'(9);
  localparam logic [HW-1:0] ADJ     = HW'(6);

  logic          lo_fix, hi_fix;
  logic [DW:0]   step1;
  logic [HW:0]   half;

  always_comb begin
    lo_fix = (a[HW-1:0] > DIG_MAX) | ac_in;
    step1  = {1'b0, a} + (lo_fix ? {{(DW+1-HW){1'b0}}, ADJ} : '0);
    half   = {1'b0, a[HW-1:0]} + (lo_fix ? {1'b0, ADJ} : '0);
    ac_out = half[HW];
    hi_fix = cy_in | step1[DW] | (step1[DW-1:HW] > DIG_MAX);
    res    = step1[DW-1:0] + (hi_fix ? {ADJ, {HW{1'b0}}} : '0);
    cy_out = hi_fix;
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e           op,
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic [FLAG_W-1:0] flg_in,
  output logic [DW-1:0]     res,
  output logic [FLAG_W-1:0] flg_out,
  output logic              we
);
  localparam int HW = DW / 2;

  logic          step_op, sub_op, cin;
  logic [DW-1:0] ax, ay, asum, dres;
  logic          acout, ahout, dac, dcy;
  logic          s, z, ac, p, cy, szp;

  always_comb begin
    step_op = (op == OP_INC) || (op == OP_DEC);
    sub_op  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_DEC);
    cin     = ((op == OP_ADC) || (op == OP_SBB)) && flg_in[F_CY];
    ax      = step_op ? b : a;
    ay      = step_op ? DW'(1) : b;
  end

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .x(ax), .y(ay), .cin(cin), .sub(sub_op),
    .sum(asum), .cout(acout), .hout(ahout)
  );

  acc_alu_daa #(.DW(DW)) u_daa (
    .a(a), .ac_in(flg_in[F_AC]), .cy_in(flg_in[F_CY]),
    .res(dres), .ac_out(dac), .cy_out(dcy)
  );

  always_comb begin
    res = a;
    we  = 1'b0;
    szp = 1'b0;
    s   = flg_in[F_S];
    z   = flg_in[F_Z];
    ac  = flg_in[F_AC];
    p   = flg_in[F_P];
    cy  = flg_in[F_CY];
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
        res = asum; cy = acout; ac = ahout; szp = 1'b1;
        we  = (op != OP_CMP);
      end
      OP_AND, OP_ANDI: begin
        res = a & b; cy = 1'b0; szp = 1'b1; we = 1'b1;
        ac  = (op == OP_AND) ? (a[HW-1] | b[HW-1]) : 1'b0;
      end
      OP_XOR: begin res = a ^ b; cy = 1'b0; ac = 1'b0; szp = 1'b1; we = 1'b1; end
      OP_OR:  begin res = a | b; cy = 1'b0; ac = 1'b0; szp = 1'b1; we = 1'b1; end
      OP_INC, OP_DEC: begin res = asum; ac = ahout; szp = 1'b1; end
      OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy = a[DW-1]; we = 1'b1; end
      OP_RRC: begin res = {a[0], a[DW-1:1]};    cy = a[0];    we = 1'b1; end
      OP_RAL: begin res = {a[DW-2:0], cy};      cy = a[DW-1]; we = 1'b1; end
      OP_RAR: begin res = {cy, a[DW-1:1]};      cy = a[0];    we = 1'b1; end
      OP_CMA: begin res = ~a; we = 1'b1; end
      OP_STC: cy = 1'b1;
      OP_CMC: cy = ~cy;
      OP_DAA: begin res = dres; ac = dac; cy = dcy; szp = 1'b1; we = 1'b1; end
      default: ;
    endcase
    if (szp) begin
      s = res[DW-1];
      z = (res == '0);
      p = ~^res;
    end
    flg_out        = (flg_in & FLAG_LIVE) | FLAG_ONES;
    flg_out[F_S]   = s;
    flg_out[F_Z]   = z;
    flg_out[F_AC]  = ac;
    flg_out[F_P]   = p;
    flg_out[F_CY]  = cy;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [4:0]        op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  output logic [DW-1:0]     res_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DW-1:0]     nres;
  logic [FLAG_W-1:0] nflg;
  logic              nwe;

  acc_alu_exec #(.DW(DW)) u_exec (
    .op(alu_op_e'(op_i)), .a(acc_i), .b(opnd_i), .flg_in(flags_o),
    .res(nres), .flg_out(nflg), .we(nwe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o    <= '0;
      acc_we_o <= 1'b0;
      flags_o  <= FLAG_ONES;
    end else if (exec_i) begin
      res_o    <= nres;
      acc_we_o <= nwe;
      flags_o  <= nflg;
    end else begin
      acc_we_o <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          exec_i,
  input logic [4:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] res_o,
  input logic          acc_we_o,
  input logic [7:0]    flags_o
);
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (flags_o & 8'h2A) == 8'h02);

  p_cmp_nowb_r4: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 5'd7) |=> !acc_we_o);

  p_logic_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (op_i == 5'd5 || op_i == 5'd6 || op_i == 5'd18))
      |=> (!flags_o[0] && !flags_o[4]));

  p_step_keep_cy_r6: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (op_i == 5'd8 || op_i == 5'd9))
      |=> (flags_o[0] == $past(flags_o[0]) && !acc_we_o));

  p_rot_only_cy_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i >= 5'd10 && op_i <= 5'd13)
      |=> (flags_o[7:1] == $past(flags_o[7:1])));

  p_cma_r8: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 5'd14)
      |=> (res_o == ~$past(acc_i) && $stable(flags_o) && acc_we_o));

  p_stc_r9: assert property (@(posedge clk) disable iff (rst)
    (exec_i && op_i == 5'd15)
      |=> (flags_o[0] && flags_o[7:1] == $past(flags_o[7:1]) && !acc_we_o));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> ($stable(flags_o) && $stable(res_o) && !acc_we_o));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .acc_i(acc_i),
  .res_o(res_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = 5'd0;
  logic [7:0] acc_i = 8'h00;
  logic [7:0] opnd_i = 8'h00;
  logic [7:0] res_o;
  logic       acc_we_o;
  logic [7:0] flags_o;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .res_o(res_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  // {req, op, acc, opnd, exp_res, exp_flags, exp_we}; flags chain in order
  localparam int NV = 27;
  localparam logic [41:0] VEC [NV] = '{
    {4'd3,  5'd0,  8'h3A, 8'hC6, 8'h00, 8'h57, 1'b1}, // R3 add, carry+half
    {4'd3,  5'd1,  8'h10, 8'h0F, 8'h20, 8'h12, 1'b1}, // R3 add with carry in
    {4'd3,  5'd2,  8'h05, 8'h07, 8'hFE, 8'h93, 1'b1}, // R3 subtract borrow
    {4'd3,  5'd3,  8'h50, 8'h20, 8'h2F, 8'h12, 1'b1}, // R3 borrow in
    {4'd4,  5'd7,  8'h40, 8'h40, 8'h00, 8'h46, 1'b0}, // R4 compare equal
    {4'd4,  5'd7,  8'h10, 8'h20, 8'hF0, 8'h87, 1'b0}, // R4 compare below
    {4'd12, 5'd4,  8'hF8, 8'h1F, 8'h18, 8'h16, 1'b1}, // R12 even parity, R5 AND
    {4'd5,  5'd18, 8'h0F, 8'h08, 8'h08, 8'h02, 1'b1}, // R5 AND imm, odd
    {4'd9,  5'd15, 8'h55, 8'h00, 8'h55, 8'h03, 1'b0}, // R9 set carry
    {4'd5,  5'd5,  8'hFF, 8'hFF, 8'h00, 8'h46, 1'b1}, // R5 XOR clears carry
    {4'd9,  5'd15, 8'h00, 8'h00, 8'h00, 8'h47, 1'b0}, // R9 set carry keeps Z,P
    {4'd5,  5'd6,  8'h80, 8'h01, 8'h81, 8'h86, 1'b1}, // R5 OR
    {4'd9,  5'd16, 8'h12, 8'h00, 8'h12, 8'h87, 1'b0}, // R9 invert carry
    {4'd6,  5'd8,  8'h33, 8'hFF, 8'h00, 8'h57, 1'b0}, // R6 step up wraps
    {4'd6,  5'd9,  8'h33, 8'h00, 8'hFF, 8'h97, 1'b0}, // R6 step down wraps
    {4'd9,  5'd16, 8'h00, 8'h00, 8'h00, 8'h96, 1'b0}, // R9 invert carry
    {4'd6,  5'd8,  8'h33, 8'h7F, 8'h80, 8'h92, 1'b0}, // R6 into sign
    {4'd7,  5'd10, 8'h81, 8'h00, 8'h03, 8'h93, 1'b1}, // R7 left circular
    {4'd7,  5'd11, 8'h02, 8'h00, 8'h01, 8'h92, 1'b1}, // R7 right circular
    {4'd7,  5'd12, 8'h80, 8'h00, 8'h00, 8'h93, 1'b1}, // R7 left via carry
    {4'd7,  5'd13, 8'h02, 8'h00, 8'h81, 8'h92, 1'b1}, // R7 right via carry
    {4'd8,  5'd14, 8'h5A, 8'h00, 8'hA5, 8'h92, 1'b1}, // R8 complement
    {4'd10, 5'd17, 8'h13, 8'h00, 8'h19, 8'h02, 1'b1}, // R10 low fix via AC
    {4'd3,  5'd0,  8'h38, 8'h45, 8'h7D, 8'h06, 1'b1}, // R3 BCD-ish add
    {4'd10, 5'd17, 8'h7D, 8'h00, 8'h83, 8'h92, 1'b1}, // R10 low digit > 9
    {4'd10, 5'd17, 8'h9A, 8'h00, 8'h00, 8'h57, 1'b1}, // R10 both fixes
    {4'd10, 5'd17, 8'h22, 8'h00, 8'h88, 8'h87, 1'b1}  // R10 high fix via CY
  };

  task automatic check8(input int req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check8(1, "res after reset", res_o, 8'h00);
    check8(1, "we after reset", {7'd0, acc_we_o}, 8'h00);
    check8(1, "flags after reset", flags_o, 8'h02);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      op_i   = VEC[i][37:33];
      acc_i  = VEC[i][32:25];
      opnd_i = VEC[i][24:17];
      exec_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check8(int'(VEC[i][41:38]), $sformatf("vec %0d res", i), res_o, VEC[i][16:9]);
      check8(int'(VEC[i][41:38]), $sformatf("vec %0d flags", i), flags_o, VEC[i][8:1]);
      check8(int'(VEC[i][41:38]), $sformatf("vec %0d we", i), {7'd0, acc_we_o}, {7'd0, VEC[i][0]});
    end

    // R2 fixed flag bits after the chain
    check8(2, "fixed flag bits", flags_o & 8'h2A, 8'h02);

    // R11 idle edge: ADD presented but not executed
    exec_i = 1'b0; op_i = 5'd0; acc_i = 8'h01; opnd_i = 8'h01;
    @(posedge clk); @(negedge clk);
    check8(11, "idle res hold", res_o, 8'h88);
    check8(11, "idle flags hold", flags_o, 8'h87);
    check8(11, "idle we low", {7'd0, acc_we_o}, 8'h00);

    // R1 reset mid-run overrides a pending operation
    exec_i = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check8(1, "flags after late reset", flags_o, 8'h02);
    check8(1, "res after late reset", res_o, 8'h00);
    rst = 1'b0; exec_i = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule